// File: doc/BRIEF.md
# SPI Status Flag Register

This block keeps the sticky status flags of a queued SPI controller and shows them as one 32-bit status word. The transfer engine, the FIFOs and the DMA controller stay outside it. They reach the block as single-cycle event strobes and level inputs. Software clears a flag by writing a 1 to its bit position on a plain 32-bit write port.

Three flags are sticky: end of queue, transmit underflow and receive overflow. Each has its own set condition. Each stays at 1 until software clears it. The fourth flag is a transmit fill request. It follows the transmit FIFO level, and after a clear by software or by a DMA acknowledge it returns by itself. The block also keeps a transfer-running bit. It drives a DMA request and an interrupt line built from the flags.

Each flag is a small state machine. A sticky flag has two states: `FLAG_CLEAR` and `FLAG_SET`.
- `FLAG_CLEAR` goes to `FLAG_SET` on its set event.
- `FLAG_SET` goes back to `FLAG_CLEAR` on a write-one-to-clear with no set event in the same cycle.

The fill request has three states: `FILL_BLOCKED`, `FILL_ASK` and `FILL_HELD`.
- Any state goes to `FILL_BLOCKED` while the FIFO is full.
- `FILL_ASK` goes to `FILL_HELD` on a clear.
- `FILL_HELD` goes to `FILL_ASK` when the FIFO is not full.
- `FILL_BLOCKED` goes to `FILL_ASK` when the FIFO is not full.

The transfer-running bit has two states: `RUN_IDLE` and `RUN_ACTIVE`.
- `RUN_IDLE` goes to `RUN_ACTIVE` on a start, provided there is no stop and no end-of-queue event in that cycle.
- `RUN_ACTIVE` goes to `RUN_IDLE` on a halt or on an end-of-queue event.

Top module: `spi_status_flags`

## Requirements
- R1: The end-of-queue flag (status bit 28) becomes 1 one cycle after `frame_done` and `frame_eoq` are both high while `master_mode` is 1. It does not set when `master_mode` is 0.
- R2: `running_o` becomes 1 the cycle after `run_start` and 0 the cycle after `run_halt`. An end-of-queue set event clears it in the same cycle in which bit 28 sets, and this wins over a simultaneous `run_start`.
- R3: The underflow flag (bit 27) becomes 1 one cycle after `frame_start` is high while `master_mode` is 0 and `tx_empty` is 1. It never sets in master mode.
- R4: The fill-request flag (bit 25) is 1 in every cycle after one in which `tx_full` was 0 and no clear applied. It is 0 in the cycle after `tx_full` was 1.
- R5: A write with `wr_data[25]`=1, or a `dma_ack`, clears bit 25 for one cycle. If `tx_full` stays 0, bit 25 returns to 1 on the following cycle with no fresh event.
- R6: The overflow flag (bit 19) becomes 1 one cycle after `frame_start` is high while `rx_full` (receive FIFO and shift register both full) is 1, in either mode.
- R7: Bits 28, 27 and 19 hold until a write with 1 in that bit position. A write of 0 has no effect. A set event in the same cycle as its clear leaves the flag at 1.
- R8: Every status bit other than 28, 27, 25 and 19 reads 0.
- R9: `dma_req_o` equals bit 25 when `dma_en` is 1 and is 0 otherwise. `irq_o` is the OR of the four flags, each ANDed with its enable: `irq_en[0]` for bit 28, `[1]` for bit 27, `[2]` for bit 25, `[3]` for bit 19.
- R10: After a synchronous reset (`rst_n`=0 at a clock edge), bits 28, 27 and 19 and `running_o` are 0, and bit 25 equals the inverse of `tx_full` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| frame_start | input | 1 | Strobe: a frame begins |
| frame_done | input | 1 | Strobe: a frame finishes |
| frame_eoq | input | 1 | Finishing frame carries the end-of-queue marker |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_full | input | 1 | Transmit FIFO is full |
| rx_full | input | 1 | Receive FIFO and shift register both full |
| run_start | input | 1 | Strobe: start transfers |
| run_halt | input | 1 | Strobe: stop transfers |
| dma_en | input | 1 | Route fill request to DMA |
| dma_ack | input | 1 | DMA acknowledge of fill request |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write-one-to-clear data |
| irq_en | input | 4 | Interrupt enables per flag |
| status_o | output | 32 | Status word |
| running_o | output | 1 | Transfer-running bit |
| dma_req_o | output | 1 | DMA fill request |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 32-bit status width and the fixed flag positions. With so few inputs, the bench sweeps every combination of the mode, the frame strobes, `tx_empty` and `rx_full` from a freshly cleared state. For each combination it computes the expected word as an arithmetic sum of the bit weights. It also sweeps all sixteen interrupt enable values against a fully set flag word. Directed sequences reach the timed behaviour: the one-cycle fill gap, set-versus-clear collisions, and reset with the FIFO both full and not full.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    localparam int STAT_W   = 32;
    localparam int EOQ_BIT  = 28;
    localparam int UFL_BIT  = 27;
    localparam int FILL_BIT = 25;
    localparam int OVF_BIT  = 19;
    localparam int N_STICKY = 3;
    localparam int N_IRQ    = 4;

    localparam int STK_EOQ = 0;
    localparam int STK_UFL = 1;
    localparam int STK_OVF = 2;

    localparam logic [STAT_W-1:0] FLAG_MASK =
        (STAT_W'(1) << EOQ_BIT) | (STAT_W'(1) << UFL_BIT) |
        (STAT_W'(1) << FILL_BIT) | (STAT_W'(1) << OVF_BIT);

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_SET
    } flag_state_e;

    typedef enum logic [1:0] {
        FILL_BLOCKED,
        FILL_ASK,
        FILL_HELD
    } fill_state_e;

    typedef enum logic {
        RUN_IDLE,
        RUN_ACTIVE
    } run_state_e;

    function automatic int sticky_pos(input int idx);
        case (idx)
            STK_EOQ: return EOQ_BIT;
            STK_UFL: return UFL_BIT;
            default: return OVF_BIT;
        endcase
    endfunction
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_i) state_d = FLAG_SET;
            FLAG_SET:   if (clr_i && !set_i) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_SET);
    end
endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full_i,
    input  logic clr_i,
    output logic flag_o
);
    fill_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= full_i ? FILL_BLOCKED : FILL_ASK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_BLOCKED: if (!full_i) state_d = FILL_ASK;
            FILL_ASK: begin
                if (full_i)     state_d = FILL_BLOCKED;
                else if (clr_i) state_d = FILL_HELD;
            end
            FILL_HELD: state_d = full_i ? FILL_BLOCKED : FILL_ASK;
            default:   state_d = FILL_BLOCKED;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FILL_ASK);
    end
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
    import spi_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic halt_i,
    input  logic eoq_evt_i,
    output logic run_o
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE:   if (start_i && !halt_i && !eoq_evt_i) state_d = RUN_ACTIVE;
            RUN_ACTIVE: if (halt_i || eoq_evt_i) state_d = RUN_IDLE;
            default:    state_d = RUN_IDLE;
        endcase
    end

    always_comb begin
        run_o = (state_q == RUN_ACTIVE);
    end
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic              frame_eoq,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              run_start,
    input  logic              run_halt,
    input  logic              dma_en,
    input  logic              dma_ack,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [N_IRQ-1:0]  irq_en,
    output logic [STAT_W-1:0] status_o,
    output logic              running_o,
    output logic              dma_req_o,
    output logic              irq_o
);
    logic [N_STICKY-1:0] set_vec;
    logic [N_STICKY-1:0] clr_vec;
    logic [N_STICKY-1:0] sticky_q;
    logic                fill_flag;
    logic                fill_clr;
    logic                unused_wr_bits;
    logic [N_IRQ-1:0]    flag_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[STK_EOQ] = master_mode && frame_done && frame_eoq;
        set_vec[STK_UFL] = !master_mode && frame_start && tx_empty;
        set_vec[STK_OVF] = frame_start && rx_full;
    end

    generate
        for (genvar gi = 0; gi < N_STICKY; gi++) begin : g_sticky
            localparam int POS = sticky_pos(gi);
            assign clr_vec[gi] = wr_en && wr_data[POS];
            sticky_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[gi]),
                .clr_i  (clr_vec[gi]),
                .flag_o (sticky_q[gi])
            );
        end
    endgenerate

    assign fill_clr = (wr_en && wr_data[FILL_BIT]) || dma_ack;

    fill_ctrl u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .full_i (tx_full),
        .clr_i  (fill_clr),
        .flag_o (fill_flag)
    );

    run_ctrl u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (run_start),
        .halt_i    (run_halt),
        .eoq_evt_i (set_vec[STK_EOQ]),
        .run_o     (running_o)
    );

    always_comb begin
        status_o           = '0;
        status_o[EOQ_BIT]  = sticky_q[STK_EOQ];
        status_o[UFL_BIT]  = sticky_q[STK_UFL];
        status_o[FILL_BIT] = fill_flag;
        status_o[OVF_BIT]  = sticky_q[STK_OVF];
    end

    assign flag_vec       = {sticky_q[STK_OVF], fill_flag, sticky_q[STK_UFL], sticky_q[STK_EOQ]};
    assign irq_o          = |(flag_vec & irq_en);
    assign dma_req_o      = dma_en && fill_flag;
    assign unused_wr_bits = ^(wr_data & ~FLAG_MASK);
endmodule

// File: rtl/spi_status_flags_chk.sv
module spi_status_flags_chk
    import spi_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              frame_start,
    input logic              frame_done,
    input logic              frame_eoq,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              rx_full,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic [N_IRQ-1:0]  irq_en,
    input logic [STAT_W-1:0] status_o,
    input logic              running_o,
    input logic              irq_o
);
    AST_EOQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode && frame_done && frame_eoq |=> status_o[EOQ_BIT]); // R1
    AST_EOQ_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode && frame_done && frame_eoq |=> !running_o); // R2
    AST_UFL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode && frame_start && tx_empty |=> status_o[UFL_BIT]); // R3
    AST_UFL_NOT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode && !status_o[UFL_BIT] |=> !status_o[UFL_BIT]); // R3
    AST_FILL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |=> !status_o[FILL_BIT]); // R4
    AST_FILL_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_full && !status_o[FILL_BIT] |=> status_o[FILL_BIT]); // R5
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start && rx_full |=> status_o[OVF_BIT]); // R6
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[EOQ_BIT] && !(wr_en && wr_data[EOQ_BIT]) |=> status_o[EOQ_BIT]); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~FLAG_MASK) == '0); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en == '0 |-> !irq_o); // R9
endmodule

bind spi_status_flags spi_status_flags_chk u_chk (.*);

// File: tb/tb_spi_status_flags.sv
module tb_spi_status_flags;
    logic        clk = 1'b0;
    logic        rst_n, master_mode, frame_start, frame_done, frame_eoq;
    logic        tx_empty, tx_full, rx_full, run_start, run_halt;
    logic        dma_en, dma_ack, wr_en;
    logic [31:0] wr_data;
    logic [3:0]  irq_en;
    logic [31:0] status_o;
    logic        running_o, dma_req_o, irq_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    localparam logic [31:0] W_EOQ  = 32'h1000_0000;
    localparam logic [31:0] W_UFL  = 32'h0800_0000;
    localparam logic [31:0] W_FILL = 32'h0200_0000;
    localparam logic [31:0] W_OVF  = 32'h0008_0000;

    always #5 clk = ~clk;

    spi_status_flags dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        frame_start = 0; frame_done = 0; frame_eoq = 0; run_start = 0;
        run_halt = 0; dma_ack = 0; wr_en = 0; wr_data = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        quiet();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        quiet();
        master_mode = 1; tx_empty = 0; tx_full = 0; rx_full = 0;
        dma_en = 0; irq_en = '0;
        // R10: reset with FIFO not full
        rst_n = 0; tick(); tick(); rst_n = 1;
        chk("R10 status after reset, not full", status_o, W_FILL);
        chk("R10 running after reset", {31'b0, running_o}, 0);
        // R10: reset with FIFO full
        tx_full = 1; rst_n = 0; tick(); rst_n = 1;
        chk("R10 status after reset, full", status_o, 0);
        tx_full = 0; tick();
        chk("R4 fill after full drops", status_o, W_FILL);

        // R1 R2 R3 R6 R8: sweep all event combinations
        for (int v = 0; v < 64; v++) begin
            logic m, s, d, e, te, rf;
            logic [31:0] exp;
            {m, s, d, e, te, rf} = v[5:0];
            tx_full = 1; wr_en = 1; wr_data = '1; run_start = 1;
            @(posedge clk); #1; quiet();
            tx_full = 0; master_mode = m; frame_start = s; frame_done = d;
            frame_eoq = e; tx_empty = te; rx_full = rf;
            tick();
            exp = W_FILL + (m & d & e ? W_EOQ : 0) + (!m & s & te ? W_UFL : 0)
                + (s & rf ? W_OVF : 0);
            chk("R1 R3 R6 R8 sweep status", status_o, exp);
            chk("R2 sweep running", {31'b0, running_o}, {31'b0, !(m & d & e)});
        end
        tx_empty = 0; rx_full = 0; master_mode = 1;

        // R2: halt; eoq beats start
        run_start = 1; tick();
        chk("R2 start", {31'b0, running_o}, 1);
        run_halt = 1; tick();
        chk("R2 halt", {31'b0, running_o}, 0);
        run_start = 1; frame_done = 1; frame_eoq = 1; tick();
        chk("R2 eoq beats start", {31'b0, running_o}, 0);
        frame_done = 1; frame_eoq = 0; tick();
        chk("R1 no marker keeps eoq", status_o & W_EOQ, W_EOQ);

        // R7: write 0 no effect, selective clear, set wins
        master_mode = 0; tx_empty = 1; rx_full = 1; frame_start = 1; tick();
        tx_empty = 0; rx_full = 0;
        chk("R7 all set", status_o, W_EOQ | W_UFL | W_OVF | W_FILL);
        wr_en = 1; wr_data = ~(W_EOQ | W_UFL | W_OVF | W_FILL); tick();
        chk("R7 write zeros no effect", status_o, W_EOQ | W_UFL | W_OVF | W_FILL);
        wr_en = 1; wr_data = W_EOQ; tick();
        chk("R7 clear eoq only", status_o, W_UFL | W_OVF | W_FILL);
        rx_full = 1; frame_start = 1; wr_en = 1; wr_data = W_OVF; tick();
        rx_full = 0;
        chk("R7 set wins over clear", status_o & W_OVF, W_OVF);
        wr_en = 1; wr_data = W_UFL | W_OVF; tick();
        chk("R7 clear both", status_o, W_FILL);

        // R5 R9: fill gap by write and DMA ack
        dma_en = 1;
        wr_en = 1; wr_data = W_FILL; tick();
        chk("R5 write clears fill", status_o, 0);
        tick();
        chk("R5 fill returns", status_o, W_FILL);
        dma_ack = 1; tick();
        chk("R9 dma req drops after ack", {31'b0, dma_req_o}, 0);
        tick();
        chk("R9 dma req returns", {31'b0, dma_req_o}, 1);
        dma_en = 0; #1;
        chk("R9 dma req off when disabled", {31'b0, dma_req_o}, 0);
        tx_full = 1; dma_en = 1; tick();
        chk("R4 full blocks fill", {status_o[25], dma_req_o}, 0);
        tx_full = 0; tick();

        // R9: interrupt enable sweep, all flags set
        master_mode = 1; frame_done = 1; frame_eoq = 1; tick();
        master_mode = 0; tx_empty = 1; rx_full = 1; frame_start = 1; tick();
        tx_empty = 0; rx_full = 0;
        for (int k = 0; k < 16; k++) begin
            irq_en = 4'(k); #1;
            chk("R9 irq all flags", {31'b0, irq_o}, {31'b0, k != 0});
        end
        wr_en = 1; wr_data = W_EOQ | W_OVF; tick();
        for (int k = 0; k < 16; k++) begin
            irq_en = 4'(k); #1;
            chk("R9 irq partial flags", {31'b0, irq_o}, {31'b0, (k & 6) != 0});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule